// File: doc/BRIEF.md
# Real-Time Clock Digital Rate Trim

This block turns a stream of oscillator ticks into a once-per-second strobe and corrects the oscillator's rate error in logic. The oscillator is never retuned. Instead, selected seconds are shortened or stretched by a fixed number of ticks. The corrections are spread across a repeating window of 64 minutes, and each corrected minute has exactly one corrected second: the first second of that minute.

A 5-bit magnitude and a direction bit set the trim. With magnitude N, the first 2N minutes of each window are corrected. This allows at most 62 corrected minutes, so the last two minutes of the window are never touched. Speeding up removes a small number of ticks from the corrected second, and slowing down adds twice that number. The block takes a new trim setting only at the first tick of a window, so a change made part-way through a window never splits that window between two settings.

A test mode puts out a square wave at a fixed fraction of the nominal tick rate, 512 Hz at 32,768 ticks per second. The trim setting does not change this wave, so it can be measured to find the raw oscillator error. The block also gives a minute strobe for the calendar counters that sit after it.

Top module: `rtc_trim_core`

## Requirements
- R1: With magnitude 0, every second lasts exactly TICKS_PER_SEC counted ticks (default 32,768). Any second that is not a corrected second also lasts TICKS_PER_SEC ticks.
- R2: A corrected second lasts TICKS_PER_SEC minus SHORTEN_TICKS ticks (default 128) when the direction bit `trim_fast` is 1. It lasts TICKS_PER_SEC plus STRETCH_TICKS ticks (default 256) when `trim_fast` is 0.
- R3: The corrected seconds are second 0 of minutes 0 through 2N-1 of each window, where N is the value of `trim_mag` (0 to 31). Each window therefore holds exactly 2N corrected seconds, and at N = 31 minutes 62 and 63 stay nominal.
- R4: A window is CYCLE_MIN minutes (default 64), and each minute is SEC_PER_MIN seconds (default 60). `min_strobe` is high only in the same cycle as the `sec_strobe` that ends the last second of a minute.
- R5: The trim setting is sampled only at the first counted tick of a window, including the first tick after reset. A change at any other time has no effect until the next window starts.
- R6: Only clock cycles with `osc_tick` high are counted. `sec_strobe` is a single-cycle pulse in the clock cycle after the tick that completes a second.
- R7: While `test_en` is 1, `test_wave` toggles every TICKS_PER_SEC/(2*WAVE_HZ) counted ticks, whatever the trim setting. While `test_en` is 0, `test_wave` is 0 from the next cycle on.
- R8: During reset, `sec_strobe`, `min_strobe` and `test_wave` are 0, and the tick, second and minute counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One oscillator period has elapsed (sampled each clock) |
| trim_mag | input | 5 | Trim magnitude N; corrects the first 2N minutes of a window |
| trim_fast | input | 1 | Trim direction: 1 shortens, 0 lengthens corrected seconds |
| test_en | input | 1 | Enables the fixed-rate test square wave |
| sec_strobe | output | 1 | One-cycle pulse at the end of each second |
| min_strobe | output | 1 | One-cycle pulse with the strobe ending a minute |
| test_wave | output | 1 | Test square wave, 0 when disabled |

## Verification
Every result is registered once after the tick that causes it. `sec_strobe` and `min_strobe` rise in the cycle after the completing tick, and `test_wave` changes in the cycle after the tick that finishes a half period. The bench therefore samples on the falling edge and, at that sample, counts the tick taken at the rising edge just before. It measures each second, and each half period of the wave, as a difference of these tick counts, not as a count of clock cycles. For that reason the run with gapped ticks uses the same expected values. Trim changes are applied halfway through a window and checked against the totals of the following window, which confirms that a new setting takes effect one full window boundary later.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int TRIM_MAG_W = 5;

    typedef struct packed {
        logic [TRIM_MAG_W-1:0] mag;
        logic                  fast;
    } trim_set_t;

endpackage

// File: rtl/rtc_trim_ctrl.sv
module rtc_trim_ctrl
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SHORTEN_TICKS = 128,
    parameter int STRETCH_TICKS = 256,
    parameter int SEC_W         = 6,
    parameter int MIN_W         = 6,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             cnt_zero,
    input  logic             at_start,
    input  trim_set_t        trim_in,
    input  logic [SEC_W-1:0] sec_idx,
    input  logic [MIN_W-1:0] min_idx,
    output logic [CNT_W-1:0] sec_len
);
    localparam logic [CNT_W-1:0] NOM_LEN   = CNT_W'(TICKS_PER_SEC);
    localparam logic [CNT_W-1:0] FAST_LEN  = CNT_W'(TICKS_PER_SEC - SHORTEN_TICKS);
    localparam logic [CNT_W-1:0] SLOW_LEN  = CNT_W'(TICKS_PER_SEC + STRETCH_TICKS);

    typedef struct packed {
        trim_set_t active;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        load_window;
    logic [MIN_W:0] span;
    logic        adjust;

    always_comb begin
        st_d        = st_q;
        load_window = osc_tick && cnt_zero && at_start;
        if (load_window) begin
            st_d.active = trim_in;
        end
        span   = (MIN_W+1)'({st_q.active.mag, 1'b0});
        adjust = (sec_idx == '0) && ({1'b0, min_idx} < span);
        if (!adjust) begin
            sec_len = NOM_LEN;
        end else if (st_q.active.fast) begin
            sec_len = FAST_LEN;
        end else begin
            sec_len = SLOW_LEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Trim setting changes only at the first tick of a window.
    assert_trim_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_tick && cnt_zero && at_start) |=> $stable(st_q.active));

    // A non-nominal second length is only ever chosen for second 0 of a minute.
    assert_adjust_first_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_len != NOM_LEN) |-> (sec_idx == '0));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [CNT_W-1:0] sec_len,
    output logic             sec_done,
    output logic             cnt_zero,
    output logic             sec_strobe
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        sec_done    = osc_tick && (st_q.cnt == (sec_len - CNT_W'(1)));
        st_d.strobe = sec_done;
        if (sec_done) begin
            st_d.cnt = '0;
        end else if (osc_tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_zero   = (st_q.cnt == '0);
    assign sec_strobe = st_q.strobe;

    // The seconds strobe lasts a single cycle.
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |=> !sec_strobe);

    // The seconds strobe follows a counted oscillator tick.
    assert_strobe_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_strobe) |-> $past(osc_tick));

endmodule

// File: rtl/rtc_trim_minute.sv
module rtc_trim_minute #(
    parameter int SEC_PER_MIN = 60,
    parameter int CYCLE_MIN   = 64,
    parameter int SEC_W       = 6,
    parameter int MIN_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_done,
    input  logic             sec_strobe,
    output logic [SEC_W-1:0] sec_idx,
    output logic [MIN_W-1:0] min_idx,
    output logic             at_start,
    output logic             min_strobe
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYCLE_MIN - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic             mstrobe;
    } min_state_t;

    min_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.mstrobe = 1'b0;
        if (sec_done) begin
            if (st_q.sec == SEC_LAST) begin
                st_d.sec     = '0;
                st_d.mstrobe = 1'b1;
                st_d.min     = (st_q.min == MIN_LAST) ? '0 : st_q.min + MIN_W'(1);
            end else begin
                st_d.sec = st_q.sec + SEC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_idx    = st_q.sec;
    assign min_idx    = st_q.min;
    assign at_start   = (st_q.sec == '0) && (st_q.min == '0);
    assign min_strobe = st_q.mstrobe;

    // A minute ends only together with a second.
    assert_min_with_sec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        min_strobe |-> sec_strobe);

    // A minute ends exactly when the second index has returned to zero.
    assert_min_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        min_strobe |-> (sec_idx == '0));

endmodule

// File: rtl/rtc_trim_testwave.sv
module rtc_trim_testwave #(
    parameter int HALF_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic test_en,
    output logic test_wave
);
    localparam int HW = $clog2(HALF_TICKS) + 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_TICKS - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          wave;
    } wave_state_t;

    wave_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!test_en) begin
            st_d = '0;
        end else if (osc_tick) begin
            if (st_q.cnt == HALF_LAST) begin
                st_d.cnt  = '0;
                st_d.wave = !st_q.wave;
            end else begin
                st_d.cnt = st_q.cnt + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign test_wave = st_q.wave;

    // Wave is low one cycle after the test mode is off.
    assert_wave_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !test_wave);

    // Wave changes only on a counted tick.
    assert_wave_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !$stable(test_wave) && $past(test_en)) |-> $past(osc_tick));

endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SHORTEN_TICKS = 128,
    parameter int STRETCH_TICKS = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int CYCLE_MIN     = 64,
    parameter int WAVE_HZ       = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_tick,
    input  logic [TRIM_MAG_W-1:0] trim_mag,
    input  logic                  trim_fast,
    input  logic                  test_en,
    output logic                  sec_strobe,
    output logic                  min_strobe,
    output logic                  test_wave
);
    localparam int CNT_W      = $clog2(TICKS_PER_SEC + STRETCH_TICKS + 1);
    localparam int SEC_W      = $clog2(SEC_PER_MIN);
    localparam int MIN_W      = $clog2(CYCLE_MIN);
    localparam int HALF_TICKS = TICKS_PER_SEC / (2 * WAVE_HZ);

    logic [CNT_W-1:0] sec_len;
    logic             sec_done;
    logic             cnt_zero;
    logic [SEC_W-1:0] sec_idx;
    logic [MIN_W-1:0] min_idx;
    logic             at_start;
    trim_set_t        trim_in;

    assign trim_in = '{mag: trim_mag, fast: trim_fast};

    rtc_trim_ctrl #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SHORTEN_TICKS (SHORTEN_TICKS),
        .STRETCH_TICKS (STRETCH_TICKS),
        .SEC_W         (SEC_W),
        .MIN_W         (MIN_W),
        .CNT_W         (CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .cnt_zero (cnt_zero),
        .at_start (at_start),
        .trim_in  (trim_in),
        .sec_idx  (sec_idx),
        .min_idx  (min_idx),
        .sec_len  (sec_len)
    );

    rtc_trim_prescaler #(
        .CNT_W (CNT_W)
    ) pre_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .sec_len    (sec_len),
        .sec_done   (sec_done),
        .cnt_zero   (cnt_zero),
        .sec_strobe (sec_strobe)
    );

    rtc_trim_minute #(
        .SEC_PER_MIN (SEC_PER_MIN),
        .CYCLE_MIN   (CYCLE_MIN),
        .SEC_W       (SEC_W),
        .MIN_W       (MIN_W)
    ) min_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_done   (sec_done),
        .sec_strobe (sec_strobe),
        .sec_idx    (sec_idx),
        .min_idx    (min_idx),
        .at_start   (at_start),
        .min_strobe (min_strobe)
    );

    rtc_trim_testwave #(
        .HALF_TICKS (HALF_TICKS)
    ) wave_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .test_en   (test_en),
        .test_wave (test_wave)
    );

    // Outputs are quiet during reset.
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R8: assert (!sec_strobe && !min_strobe && !test_wave);
        end
    end

endmodule

// File: tb/rtc_trim_core_tb_top.sv
module rtc_trim_core_tb_top;

    localparam int T      = 128;
    localparam int S      = 16;
    localparam int L      = 32;
    localparam int SPM    = 2;
    localparam int CMIN   = 64;
    localparam int WHZ    = 32;
    localparam int HALF   = T / (2 * WHZ);
    localparam int CYCSEC = SPM * CMIN;
    localparam int NVEC   = 5;
    // Each entry: bit 5 = trim_fast, bits 4:0 = trim_mag.
    localparam logic [5:0] VEC_TAB [NVEC] = '{6'h23, 6'h03, 6'h3F, 6'h1F, 6'h01};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [4:0] trim_mag = 5'd0;
    logic       trim_fast = 1'b0;
    logic       test_en = 1'b0;
    logic       sec_strobe, min_strobe, test_wave;

    always #2 clk = ~clk;

    rtc_trim_core #(
        .TICKS_PER_SEC (T),
        .SHORTEN_TICKS (S),
        .STRETCH_TICKS (L),
        .SEC_PER_MIN   (SPM),
        .CYCLE_MIN     (CMIN),
        .WAVE_HZ       (WHZ)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .trim_mag   (trim_mag),
        .trim_fast  (trim_fast),
        .test_en    (test_en),
        .sec_strobe (sec_strobe),
        .min_strobe (min_strobe),
        .test_wave  (test_wave)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor state
    logic live_q = 1'b0;
    int   ticks_done = 0;
    int   mark = 0;
    int   n_sec = 0;
    int   cur_mag = 0;
    bit   cur_fast = 0;
    int   cyc_tot [8];
    int   cyc_adj [8];
    bit   prev_strobe = 0;
    bit   gap_mode = 0;
    bit   wave_chk_en = 0;
    bit   have_wave = 0;
    logic wave_prev = 1'b0;
    int   wave_mark = 0;

    always @(posedge clk) live_q <= rst_n;

    always @(negedge clk) begin
        if (live_q) begin
            ticks_done += int'(osc_tick);
            if (sec_strobe) begin
                int len, idx, s, m, exp_len, cyc;
                bit adj;
                len  = ticks_done - mark;
                mark = ticks_done;
                idx  = n_sec % CYCSEC;
                s    = idx % SPM;
                m    = idx / SPM;
                adj  = (s == 0) && (m < 2 * cur_mag);
                exp_len = !adj ? T : (cur_fast ? T - S : T + L);
                if (adj) chk(cur_fast ? "R2" : "R2", "corrected second length (R3 position)", len, exp_len);
                else     chk("R1", "nominal second length", len, exp_len);
                chk("R4", "minute strobe with second", int'(min_strobe), int'(s == SPM - 1));
                chk("R6", "strobe single cycle", int'(prev_strobe), 0);
                cyc = n_sec / CYCSEC;
                if (cyc < 8) begin
                    cyc_tot[cyc] += len;
                    cyc_adj[cyc] += int'(adj && (len != T));
                end
                n_sec++;
                if (n_sec % CYCSEC == 0) begin
                    cur_mag  = int'(trim_mag);
                    cur_fast = trim_fast;
                end
            end else if (min_strobe) begin
                chk("R4", "minute strobe without second", 1, 0);
            end
            if (wave_chk_en && (test_wave != wave_prev)) begin
                if (have_wave) chk("R7", "test wave half period ticks", ticks_done - wave_mark, HALF);
                have_wave = 1;
                wave_mark = ticks_done;
            end
        end
        prev_strobe = sec_strobe;
        wave_prev   = test_wave;
        osc_tick    = gap_mode ? ~osc_tick : 1'b1;
    end

    task automatic wait_sec(input int target);
        while (n_sec < target) @(negedge clk);
    endtask

    initial begin
        foreach (cyc_tot[i]) begin
            cyc_tot[i] = 0;
            cyc_adj[i] = 0;
        end
        // Reset state (R8)
        repeat (5) @(negedge clk);
        chk("R8", "sec_strobe in reset", int'(sec_strobe), 0);
        chk("R8", "min_strobe in reset", int'(min_strobe), 0);
        test_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8", "test_wave in reset", int'(test_wave), 0);
        test_en  = 1'b0;
        cur_mag  = 0;
        cur_fast = 0;
        @(posedge clk);
        #1 rst_n = 1'b1;

        // Vector table: each vector applied mid-window, measured in the next window.
        for (int i = 0; i < NVEC; i++) begin
            wait_sec(CYCSEC * i + CYCSEC / 2);
            @(negedge clk);
            trim_fast = VEC_TAB[i][5];
            trim_mag  = VEC_TAB[i][4:0];
            gap_mode  = (i == 3);
        end
        wait_sec(CYCSEC * (NVEC + 1));
        gap_mode = 0;

        chk("R1", "window 0 total ticks with magnitude 0", cyc_tot[0], CYCSEC * T);
        chk("R1", "window 0 corrected seconds", cyc_adj[0], 0);
        for (int i = 0; i < NVEC; i++) begin
            int mag, exp_tot;
            mag = int'(VEC_TAB[i][4:0]);
            exp_tot = CYCSEC * T + (VEC_TAB[i][5] ? -2 * mag * S : 2 * mag * L);
            // The window in which the vector was written keeps the older setting (R5).
            chk("R5", "window total after mid-window change", cyc_tot[i + 1], exp_tot);
            chk("R3", "corrected seconds per window", cyc_adj[i + 1], 2 * mag);
        end

        // Test wave (R7): off, then on under a maximal trim.
        trim_mag  = 5'd31;
        trim_fast = 1'b1;
        chk("R7", "test wave low while disabled", int'(test_wave), 0);
        test_en = 1'b1;
        repeat (3) @(negedge clk);
        wave_chk_en = 1;
        repeat (200) @(negedge clk);
        wave_chk_en = 0;
        chk("R7", "test wave toggled while enabled", int'(have_wave), 1);
        test_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "test wave low after disable", int'(test_wave), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule